// File: doc/BRIEF.md
# Power-Fail Recall and Store-Inhibit Supervisor

This block watches two already-synchronised supply-monitor flags, one saying the supply is above the higher switch threshold and one saying it is above the lower reset threshold. From them it decides when stores to the nonvolatile shadow must be blocked and when an automatic recall of the shadow into the working array must run. A drop below the reset threshold, or a power-on reset, arms a recall request. When the supply is back above the switch threshold, the block fires a one-cycle recall-start pulse and holds a busy flag for a fixed number of clock cycles, the restore window.

A shallow sag blocks stores for as long as it lasts but does not arm a recall. This covers a sag where the supply falls below the switch threshold and stays above the reset threshold. A sag during the restore window stops the timer and leaves the request armed. When the supply returns, the full restore window runs again. The analog comparators and the copy engine are outside this block. The copy engine consumes the start pulse and the busy flag.

Top module: `pfr_supervisor`

## Requirements
- R1: While reset is held, and in the first cycle after it, a recall request is pending: `pwrup_busy` = 1, `store_inhibit` = 1 and `recall_start` = 0.
- R2: One clock after the supply reads below the switch level, `store_inhibit` is 1. A flag pair with `vsw_ok` = 0 reads as below the switch level.
- R3: The pair `vsw_ok` = 1, `vrst_ok` = 0 is treated as below both levels. It inhibits stores and arms a recall.
- R4: Two clocks after `vrst_ok` is seen at 0, a recall request is armed and `pwrup_busy` = 1. It stays armed while the supply remains below the switch level.
- R5: A sag with `vsw_ok` = 0 and `vrst_ok` = 1 throughout arms no request. After recovery there is no `recall_start` and `pwrup_busy` stays 0.
- R6: With a request armed, `recall_start` pulses high for exactly one cycle. The pulse comes two clocks after both flags read 1.
- R7: The restore lasts RESTORE_CYCLES clocks after the start pulse. `pwrup_busy` and `store_inhibit` then fall together, and no second pulse follows.
- R8: If the supply drops below the switch level during the restore, the timer is cleared and the request stays armed. On recovery a new start pulse is issued, followed by a full RESTORE_CYCLES window.
- R9: `store_inhibit` is 1 whenever `pwrup_busy` is 1, even with the supply above the switch level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, treated as power-on |
| vsw_ok | input | 1 | Supply above the switch level (synchronised) |
| vrst_ok | input | 1 | Supply above the reset level (synchronised) |
| store_inhibit | output | 1 | Stores to the nonvolatile shadow must not start |
| recall_start | output | 1 | One-cycle pulse that launches a recall |
| pwrup_busy | output | 1 | Recall request pending or restore in progress |

## Verification
The bench separates a shallow sag from a deep one. A design that armed a recall on any drop below the switch level would pulse `recall_start` after the shallow case. It also drops the supply one cycle into a restore and then measures the full window again. A timer that merely paused would clear `pwrup_busy` too early, and a design that dropped the request would never restart. The contradictory flag pair is driven as well, to catch a decoder that trusts `vsw_ok` alone. Finally, a reset in the middle of operation must re-arm a recall.

// File: rtl/pfr_pkg.sv
// Shared types for the power-fail recall supervisor.
package pfr_pkg;
    // Qualified supply state after registration.
    typedef struct packed {
        logic ok;         // above switch level and consistent
        logic below_rst;  // below reset level
    } pfr_level_t;
endpackage

// File: rtl/pfr_level_qual.sv
// Registers the two supply flags into a qualified level.
// Assumes the flags are already synchronised. A contradictory pair
// (above switch but not above reset) counts as below both levels.
module pfr_level_qual
    import pfr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vsw_ok,
    input  logic       vrst_ok,
    output pfr_level_t level
);
    pfr_level_t level_q;

    // Register the decoded level; reset reads as unpowered-but-above-reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q.ok        <= 1'b0;
            level_q.below_rst <= 1'b0;
        end else begin
            level_q.ok        <= vsw_ok & vrst_ok;
            level_q.below_rst <= ~vrst_ok;
        end
    end

    assign level = level_q;

    // R3: contradictory flags decode as below both levels
    a_r3_bad_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (vsw_ok && !vrst_ok) |=> (!level_q.ok && level_q.below_rst));
    // R2: below switch level never reads as ok
    a_r2_low_not_ok: assert property (@(posedge clk) disable iff (!rst_n)
        !vsw_ok |=> !level_q.ok);
endmodule

// File: rtl/pfr_request_latch.sv
// Holds the pending recall request.
// Set by reset (power-on) and by a qualified drop below the reset level.
// Cleared only when the restore timer reports completion; set wins.
module pfr_request_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic below_rst,
    input  logic done,
    output logic req
);
    logic req_q;

    // Arm on low supply, disarm on completed restore.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b1;
        end else if (below_rst) begin
            req_q <= 1'b1;
        end else if (done) begin
            req_q <= 1'b0;
        end
    end

    assign req = req_q;

    // R4: a drop below the reset level arms the request
    a_r4_arm: assert property (@(posedge clk) disable iff (!rst_n)
        below_rst |=> req_q);
    // R5: the request only rises after a drop below the reset level
    a_r5_no_shallow_arm: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_q) |-> $past(below_rst));
endmodule

// File: rtl/pfr_restore_timer.sv
// Launches a recall when a request is pending and the supply is good,
// then times the restore window. A supply drop clears the window;
// completion is reported on the final counted cycle.
module pfr_restore_timer #(
    parameter int unsigned RESTORE_CYCLES = 27500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic lvl_ok,
    output logic start_pulse,
    output logic running,
    output logic done
);
    localparam int unsigned CW = (RESTORE_CYCLES > 1) ? $clog2(RESTORE_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(RESTORE_CYCLES - 1);

    logic          run_q;
    logic          start_q;
    logic [CW-1:0] cnt_q;
    logic          launch;

    assign launch = req && lvl_ok && !run_q;
    assign done   = run_q && lvl_ok && (cnt_q == LAST);

    // Start, abort, count and finish the restore window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= 1'b0;
            start_q <= 1'b0;
            cnt_q   <= '0;
        end else begin
            start_q <= launch;
            if (launch) begin
                run_q <= 1'b1;
                cnt_q <= '0;
            end else if (run_q) begin
                if (!lvl_ok || (cnt_q == LAST)) begin
                    run_q <= 1'b0;
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign start_pulse = start_q;
    assign running     = run_q;

    // R6: the start pulse lasts one cycle
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |=> !start_q);
    // R6: the pulse coincides with the first cycle of a restore
    a_r6_pulse_runs: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |-> (run_q && cnt_q == '0));
    // R8: a supply drop during a restore ends the window with the request kept
    a_r8_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && !lvl_ok) |=> (!run_q && req));
    // R7: the counter never passes the window length
    a_r7_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
endmodule

// File: rtl/pfr_supervisor.sv
// Power-fail supervisor: inhibits stores below the switch level or while
// a recall is pending, and runs the automatic recall after power-up or a
// deep brown-out. Assumes vsw_ok and vrst_ok are synchronous to clk.
module pfr_supervisor
    import pfr_pkg::*;
#(
    parameter int unsigned RESTORE_CYCLES = 27500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vsw_ok,
    input  logic vrst_ok,
    output logic store_inhibit,
    output logic recall_start,
    output logic pwrup_busy
);
    pfr_level_t level;
    logic       req;
    logic       done;
    logic       running;

    pfr_level_qual i_level (
        .clk     (clk),
        .rst_n   (rst_n),
        .vsw_ok  (vsw_ok),
        .vrst_ok (vrst_ok),
        .level   (level)
    );

    pfr_request_latch i_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .below_rst (level.below_rst),
        .done      (done),
        .req       (req)
    );

    pfr_restore_timer #(.RESTORE_CYCLES(RESTORE_CYCLES)) i_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (req),
        .lvl_ok      (level.ok),
        .start_pulse (recall_start),
        .running     (running),
        .done        (done)
    );

    assign store_inhibit = !level.ok || req;
    assign pwrup_busy    = req;

    // R9: a running restore always keeps stores blocked
    a_r9_run_inhibits: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> store_inhibit);
    // R7: busy only falls through a completed window
    a_r7_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwrup_busy) |-> $past(running));
endmodule

// File: tb/test_pfr_supervisor.sv
module test_pfr_supervisor;
    localparam int CLK_PERIOD = 10;
    localparam int NCYC = 4;
    localparam int NVEC = 17;

    // {vsw, vrst, cycles[3:0], exp_inhibit, exp_busy, exp_starts[1:0], req_tag[3:0]}
    localparam logic [13:0] VEC [NVEC] = '{
        {1'b1, 1'b1, 4'd1, 1'b1, 1'b1, 2'd0, 4'd1},  // R1 first cycle
        {1'b1, 1'b1, 4'd1, 1'b1, 1'b1, 2'd1, 4'd6},  // R6 power-up pulse
        {1'b1, 1'b1, 4'd4, 1'b0, 1'b0, 2'd0, 4'd7},  // R7 window ends
        {1'b1, 1'b1, 4'd3, 1'b0, 1'b0, 2'd0, 4'd7},  // R7 no repeat
        {1'b0, 1'b1, 4'd2, 1'b1, 1'b0, 2'd0, 4'd2},  // R2 shallow sag
        {1'b1, 1'b1, 4'd3, 1'b0, 1'b0, 2'd0, 4'd5},  // R5 no recall
        {1'b0, 1'b0, 4'd2, 1'b1, 1'b1, 2'd0, 4'd4},  // R4 deep drop
        {1'b0, 1'b1, 4'd2, 1'b1, 1'b1, 2'd0, 4'd4},  // R4 held
        {1'b1, 1'b1, 4'd2, 1'b1, 1'b1, 2'd1, 4'd9},  // R9 busy with good supply
        {1'b0, 1'b1, 4'd1, 1'b1, 1'b1, 2'd0, 4'd8},  // R8 drop in window
        {1'b0, 1'b1, 4'd2, 1'b1, 1'b1, 2'd0, 4'd8},  // R8 request kept
        {1'b1, 1'b1, 4'd2, 1'b1, 1'b1, 2'd1, 4'd8},  // R8 restart pulse
        {1'b1, 1'b1, 4'd3, 1'b1, 1'b1, 2'd0, 4'd8},  // R8 full window
        {1'b1, 1'b1, 4'd1, 1'b0, 1'b0, 2'd0, 4'd7},  // R7 end
        {1'b1, 1'b0, 4'd2, 1'b1, 1'b1, 2'd0, 4'd3},  // R3 bad pair
        {1'b1, 1'b1, 4'd2, 1'b1, 1'b1, 2'd1, 4'd3},  // R3 recall follows
        {1'b1, 1'b1, 4'd4, 1'b0, 1'b0, 2'd0, 4'd7}   // R7 end
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vsw_ok = 1'b1;
    logic vrst_ok = 1'b1;
    logic store_inhibit, recall_start, pwrup_busy;
    int   n_checks = 0;
    int   n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pfr_supervisor #(.RESTORE_CYCLES(NCYC)) i_pfr_supervisor (
        .clk           (clk),
        .rst_n         (rst_n),
        .vsw_ok        (vsw_ok),
        .vrst_ok       (vrst_ok),
        .store_inhibit (store_inhibit),
        .recall_start  (recall_start),
        .pwrup_busy    (pwrup_busy)
    );

    task automatic check(input int tag, input logic e_inh, input logic e_busy,
                         input int e_st, input int st);
        n_checks++;
        if (store_inhibit !== e_inh || pwrup_busy !== e_busy || st != e_st) begin
            n_fail++;
            $display("FAIL R%0d: inhibit=%b busy=%b starts=%0d expected inhibit=%b busy=%b starts=%0d",
                     tag, store_inhibit, pwrup_busy, st, e_inh, e_busy, e_st);
        end
    endtask

    task automatic run(input logic vs, input logic vr, input int n, output int st);
        vsw_ok  = vs;
        vrst_ok = vr;
        st = 0;
        repeat (n) begin
            @(negedge clk);
            if (recall_start) st++;
        end
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        int st;
        repeat (3) @(negedge clk);
        check(1, 1'b1, 1'b1, 0, recall_start ? 1 : 0);  // R1 during reset
        rst_n = 1'b1;
        for (int i = 0; i < NVEC; i++) begin
            run(VEC[i][13], VEC[i][12], int'(VEC[i][11:8]), st);
            check(int'(VEC[i][3:0]), VEC[i][7], VEC[i][6], int'(VEC[i][5:4]), st);
        end
        // R1: reset in mid-operation re-arms a recall
        rst_n = 1'b0;
        run(1'b1, 1'b1, 2, st);
        check(1, 1'b1, 1'b1, 0, st);
        rst_n = 1'b1;
        run(1'b1, 1'b1, 2, st);
        check(6, 1'b1, 1'b1, 1, st);   // R6 pulse after reset
        run(1'b1, 1'b1, 4, st);
        check(7, 1'b0, 1'b0, 0, st);   // R7 window after reset
        finish_run();
    end

    initial begin
        #(CLK_PERIOD * 5000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=expired expected=done");
        finish_run();
    end
endmodule